// File: doc/BRIEF.md
# Indexed Host Register Port

This block is the configuration front end of a display controller. A host reaches it through a narrow parallel port made of a 16-bit data bus, separate write and read strobes, and a data/command select line. With the select line low, a write loads an 8-bit register index. With the select line high, a write or a read targets the register at that index, and the index then moves on by itself. A host can therefore fill or dump a run of registers after sending a single index.

Behind the port sits a small bank of 8-bit control registers. Each register keeps only the bits its write mask allows. Some values are wider than a byte: a 10-bit display height, four 10-bit window corner coordinates, and two 12-bit fields for refresh and clock-synthesis control. Each of these is split across a low and a high register. Two indirect table ports, one for a 256-entry gamma table and one for a 32-entry filter table, stream data through a private pointer. An interrupt status byte collects event bits from an input vector. The host clears those bits by writing a mask that is ANDed into the status.

Read data appears on the bus one clock after the read strobe and stays there until the next read.

Top module: `idx_host_port`

## Requirements
- R1: A write with `host_dc` low loads `host_wdata[7:0]` into the index and changes no register; a read with `host_dc` low returns the current index in bits 7:0.
- R2: A write with `host_dc` high updates the indexed register and then adds 2 to the index, except at the streaming ports 0x90 (memory data), 0x5a (filter data) and 0xb8 (gamma data), where the index is left unchanged.
- R3: A read with `host_dc` high places the indexed register on `host_rdata[7:0]` one clock later, with bits 15:8 zero, and then adds 1 to the index.
- R4: Index 0x00 reads 0xA5 and index 0x02 reads 0x83, and neither changes when written. After reset `host_rdata` is 0, and the registers read as follows: 0x04=0x88, 0x08=0x14, 0x0a=0x00, 0x0c=0x32, 0x18=0x5c, 0x1a=0x02, 0x1c=0x3f, 0x1e=0x13, 0x20=0x21, 0x28=0x74, 0x2e=0x01, 0x30=0x00, 0x58=0x00, 0xb6=0x00, 0xe8=0x20, 0xf6=0x00.
- R5: The clock divider register at 0x04 stores bits 5:0 of the written value plus one. It reads back as the stored value minus one, with bit 7 set.
- R6: Split fields: the low register sets bits 7:0 and the high register sets the upper bits, and each write leaves the other part unchanged. The pairs are height 0x2e/0x30 (10 bits); window corners 0x6c/0x6e, 0x70/0x72, 0x74/0x76 and 0x78/0x7a (10 bits each); synthesis control 0x08/0x0a (12 bits); and refresh 0x18/0x1a (12 bits). A high register reads back the field shifted right by 8.
- R7: Writable-bit masks: 0x0c keeps 0x77, 0x1c keeps 0x7f, 0x1e keeps 0x17, 0x20 keeps 0x35, 0x28 keeps 0xff and 0xe8 keeps 0x1b. The other bits read 0.
- R8: Index 0xb6 sets the gamma pointer. Each write or read at 0xb8 accesses gamma entry [pointer] and then adds 1 to the pointer, which wraps from 255 to 0.
- R9: Index 0x58 sets the filter pointer to the written bits 4:0. Each write or read at 0x5a accesses filter entry [pointer] and adds 1 to the pointer, but only while the pointer is below 32. Once it reaches 32, writes are dropped, reads return 0, and the pointer stays at 32, which is also what 0x58 reads.
- R10: Each bit set in `irq_set` sets the matching bit of the interrupt status at 0xf6. A write to 0xf6 ANDs the written byte into the status, so writing a 0 clears that bit. `irq_out` is high while any status bit is set.
- R11: The non-display status register at 0xe8 always reads with bit 5 set.
- R12: Unmapped indices and the memory data port 0x90 read 0. A write to an unmapped index changes no register, but the index still advances by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_rd | input | 1 | Read strobe, ignored while `host_wr` is high |
| host_dc | input | 1 | Data/command select: low for index, high for register |
| host_wdata | input | 16 | Write data; only bits 7:0 are used |
| irq_set | input | 8 | Event bits that set interrupt status bits |
| host_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | OR of the interrupt status bits |

## Verification
The assertions assume that the host never raises `host_wr` and `host_rd` in the same cycle. The checks on write-AND clearing also assume that `irq_set` is quiet while the status register is being written. The bench holds to both: its tasks drive one strobe at a time, and it pulses `irq_set` only between accesses. The table sweeps walk each gamma entry once and run the filter pointer past its end. The pointer wrap and the ignored overflow write are therefore seen through ordinary reads of the ports.

// File: rtl/idx_host_port.sv
module idx_host_port #(
  parameter int WIN_W   = 10,
  parameter int LONG_W  = 12,
  parameter int GAMMA_N = 256,
  parameter int FILT_N  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_dc,
  input  logic [15:0] host_wdata,
  input  logic [7:0]  irq_set,
  output logic [15:0] host_rdata,
  output logic        irq_out
);
  localparam int GW = $clog2(GAMMA_N);
  localparam int FW = $clog2(FILT_N) + 1;
  localparam int NWIN = 4;

  logic [7:0]        idx;
  logic [6:0]        pll_div;
  logic [LONG_W-1:0] pll_ctl, refresh;
  logic [7:0]        pll_mode, tm0, tm1, tm2, panel, stat_ctl, irq_stat;
  logic [WIN_W-1:0]  height;
  logic [WIN_W-1:0]  win [NWIN];
  logic [GW-1:0]     gptr;
  logic [FW-1:0]     fptr;
  logic [7:0]        gamma [GAMMA_N];
  logic [7:0]        filt  [FILT_N];
  logic [7:0]        rv;

  wire [7:0] wb     = host_wdata[7:0];
  wire       do_wr  = host_wr & host_dc;
  wire       do_rd  = host_rd & ~host_wr & host_dc;
  wire       stream = (idx == 8'h90) | (idx == 8'h5a) | (idx == 8'hb8);
  wire       f_ok   = fptr < FW'(FILT_N);
  wire       in_win = (idx >= 8'h6c) && (idx <= 8'h7a) && !idx[0];
  wire [7:0] woff   = idx - 8'h6c;
  wire [1:0] wk     = woff[3:2];

  assign irq_out = |irq_stat;

  always_comb begin
    rv = 8'h00;
    case (idx)
      8'h00: rv = 8'ha5;
      8'h02: rv = 8'h83;
      8'h04: rv = {1'b1, 7'(pll_div - 7'd1)};
      8'h08: rv = pll_ctl[7:0];
      8'h0a: rv = 8'(pll_ctl >> 8);
      8'h0c: rv = pll_mode;
      8'h18: rv = refresh[7:0];
      8'h1a: rv = 8'(refresh >> 8);
      8'h1c: rv = tm0;
      8'h1e: rv = tm1;
      8'h20: rv = tm2;
      8'h28: rv = panel;
      8'h2e: rv = height[7:0];
      8'h30: rv = 8'(height >> 8);
      8'h58: rv = 8'(fptr);
      8'h5a: rv = f_ok ? filt[fptr[FW-2:0]] : 8'h00;
      8'hb6: rv = 8'(gptr);
      8'hb8: rv = gamma[gptr];
      8'he8: rv = stat_ctl | 8'h20;
      8'hf6: rv = irq_stat;
      default: if (in_win) rv = idx[1] ? 8'(win[wk] >> 8) : win[wk][7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= 8'h00;
      host_rdata <= 16'h0000;
    end else begin
      if (host_wr && !host_dc)   idx <= wb;
      else if (do_wr && !stream) idx <= idx + 8'd2;
      else if (do_rd)            idx <= idx + 8'd1;
      if (host_rd && !host_wr)   host_rdata <= {8'h00, host_dc ? rv : idx};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_div  <= 7'd9;
      pll_ctl  <= LONG_W'(12'h014);
      refresh  <= LONG_W'(12'h25c);
      pll_mode <= 8'h32;
      tm0      <= 8'h3f;
      tm1      <= 8'h13;
      tm2      <= 8'h21;
      panel    <= 8'h74;
      height   <= WIN_W'(1);
      stat_ctl <= 8'h00;
    end else if (do_wr) begin
      case (idx)
        8'h04: pll_div  <= {1'b0, wb[5:0]} + 7'd1;
        8'h08: pll_ctl[7:0] <= wb;
        8'h0a: pll_ctl[LONG_W-1:8] <= wb[LONG_W-9:0];
        8'h0c: pll_mode <= wb & 8'h77;
        8'h18: refresh[7:0] <= wb;
        8'h1a: refresh[LONG_W-1:8] <= wb[LONG_W-9:0];
        8'h1c: tm0      <= wb & 8'h7f;
        8'h1e: tm1      <= wb & 8'h17;
        8'h20: tm2      <= wb & 8'h35;
        8'h28: panel    <= wb;
        8'h2e: height[7:0] <= wb;
        8'h30: height[WIN_W-1:8] <= wb[WIN_W-9:0];
        8'he8: stat_ctl <= wb & 8'h1b;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam logic [7:0] LO = 8'h6c + 8'(4 * k);
    always_ff @(posedge clk) begin
      if (!rst_n) win[k] <= '0;
      else if (do_wr && idx == LO) win[k][7:0] <= wb;
      else if (do_wr && idx == LO + 8'd2) win[k][WIN_W-1:8] <= wb[WIN_W-9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gptr     <= '0;
      fptr     <= '0;
      irq_stat <= 8'h00;
    end else begin
      if (do_wr && idx == 8'hb6) gptr <= wb[GW-1:0];
      else if ((do_wr || do_rd) && idx == 8'hb8) gptr <= gptr + 1'b1;
      if (do_wr && idx == 8'h58) fptr <= {1'b0, wb[FW-2:0]};
      else if ((do_wr || do_rd) && idx == 8'h5a && f_ok) fptr <= fptr + 1'b1;
      irq_stat <= ((do_wr && idx == 8'hf6) ? (irq_stat & wb) : irq_stat) | irq_set;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && idx == 8'hb8) gamma[gptr] <= wb;
    if (do_wr && idx == 8'h5a && f_ok) filt[fptr[FW-2:0]] <= wb;
  end
endmodule

module idx_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic        host_dc,
  input logic [15:0] host_wdata,
  input logic [7:0]  irq_set,
  input logic [15:0] host_rdata,
  input logic        irq_out,
  input logic [7:0]  idx,
  input logic [7:0]  irq_stat
);
  p_cmd_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_dc |=> idx == $past(host_wdata[7:0]));

  p_adv_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_dc && idx != 8'h90 && idx != 8'h5a && idx != 8'hb8
    |=> idx == $past(idx) + 8'd2);

  p_stream_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_dc && (idx == 8'h90 || idx == 8'h5a || idx == 8'hb8) |=> $stable(idx));

  p_rd_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && host_dc |=> idx == $past(idx) + 8'd1 && host_rdata[15:8] == 8'h00);

  p_rev_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && host_dc && idx == 8'h00 |=> host_rdata == 16'h00a5);

  p_irq_and_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_dc && idx == 8'hf6 && irq_set == 8'h00
    |=> irq_stat == ($past(irq_stat) & $past(host_wdata[7:0])));

  p_irq_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (irq_stat != 8'h00));

  p_stat_bit5_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !host_wr && host_dc && idx == 8'he8 |=> host_rdata[5]);
endmodule

bind idx_host_port idx_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_dc(host_dc), .host_wdata(host_wdata), .irq_set(irq_set),
  .host_rdata(host_rdata), .irq_out(irq_out), .idx(idx), .irq_stat(irq_stat)
);

// File: tb/test_idx_host_port.sv
module test_idx_host_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_dc = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [7:0]  irq_set = 8'h0;
  logic [15:0] host_rdata;
  logic        irq_out;
  int          n_run = 0, n_fail = 0;
  logic [15:0] got;

  always #10 clk = ~clk;

  idx_host_port i_idx_host_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_dc(host_dc), .host_wdata(host_wdata), .irq_set(irq_set),
    .host_rdata(host_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] i);
    @(negedge clk); host_wr = 1; host_dc = 0; host_wdata = {8'hc3, i};
    @(negedge clk); host_wr = 0;
  endtask

  task automatic wd(input logic [7:0] v);
    @(negedge clk); host_wr = 1; host_dc = 1; host_wdata = {8'h5a, v};
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rdx(input logic dc, output logic [15:0] v);
    @(negedge clk); host_rd = 1; host_dc = dc;
    @(negedge clk); host_rd = 0; v = host_rdata;
  endtask

  task automatic reg_is(input string req, input logic [7:0] a, input logic [7:0] e);
    logic [15:0] v;
    cmd(a); rdx(1, v); chk(req, v, {8'h00, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ra [16] = '{8'h04,8'h08,8'h0a,8'h0c,8'h18,8'h1a,8'h1c,8'h1e,
                            8'h20,8'h28,8'h2e,8'h30,8'h58,8'hb6,8'he8,8'hf6};
    logic [7:0] rvv [16] = '{8'h88,8'h14,8'h00,8'h32,8'h5c,8'h02,8'h3f,8'h13,
                             8'h21,8'h74,8'h01,8'h00,8'h00,8'h00,8'h20,8'h00};
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset rdata", host_rdata, 16'h0000);
    for (int i = 0; i < 16; i++) reg_is("R4 reset value", ra[i], rvv[i]);
    reg_is("R4 revision", 8'h00, 8'ha5);
    reg_is("R4 config readback", 8'h02, 8'h83);
    cmd(8'h00); wd(8'h11); wd(8'h22);
    reg_is("R4 read-only 0x00", 8'h00, 8'ha5);
    reg_is("R4 read-only 0x02", 8'h02, 8'h83);

    // R1: command write loads index only
    cmd(8'h1c); cmd(8'h34);
    rdx(0, got); chk("R1 index load", got, 16'h0034);
    reg_is("R1 no register change", 8'h1c, 8'h3f);

    // R2 / R7: auto-advance by two and writable masks
    cmd(8'h1c); wd(8'hff); wd(8'hff); wd(8'hff);
    rdx(0, got); chk("R2 index after three writes", got, 16'h0022);
    reg_is("R7 mask 0x1c", 8'h1c, 8'h7f);
    reg_is("R7 mask 0x1e", 8'h1e, 8'h17);
    reg_is("R7 mask 0x20", 8'h20, 8'h35);
    cmd(8'h0c); wd(8'hff); reg_is("R7 mask 0x0c", 8'h0c, 8'h77);
    cmd(8'h28); wd(8'hff); reg_is("R7 mask 0x28", 8'h28, 8'hff);
    cmd(8'h90); wd(8'h12); wd(8'h34);
    rdx(0, got); chk("R2 stream hold 0x90", got, 16'h0090);
    cmd(8'h5a); wd(8'h00);
    rdx(0, got); chk("R2 stream hold 0x5a", got, 16'h005a);

    // R3: read advance by one
    cmd(8'h1c); rdx(1, got); chk("R3 read data", got, 16'h007f);
    rdx(0, got); chk("R3 index plus one", got, 16'h001d);

    // R12: unmapped and memory port
    cmd(8'h40); wd(8'h55);
    rdx(0, got); chk("R12 unmapped write advances", got, 16'h0042);
    reg_is("R12 unmapped reads 0", 8'h40, 8'h00);
    reg_is("R12 memory port reads 0", 8'h90, 8'h00);
    reg_is("R12 odd index reads 0", 8'h1d, 8'h00);

    // R5: divider sweep
    for (int v = 0; v < 64; v++) begin
      cmd(8'h04); wd(8'(v) | 8'hc0);
      reg_is("R5 divider", 8'h04, 8'h80 | 8'(v));
    end

    // R6: split fields
    for (int k = 0; k < 4; k++) begin
      logic [9:0] f = 10'((k * 331 + 97) % 1024);
      logic [7:0] lo = 8'h6c + 8'(4 * k);
      cmd(lo); wd(f[7:0]); wd({6'h3f, f[9:8]});
      reg_is("R6 window low", lo, f[7:0]);
      reg_is("R6 window high", lo + 8'd2, {6'h0, f[9:8]});
      cmd(lo); wd(8'h5c);
      reg_is("R6 window high preserved", lo + 8'd2, {6'h0, f[9:8]});
    end
    cmd(8'h2e); wd(8'hab); wd(8'hfe);
    reg_is("R6 height low", 8'h2e, 8'hab);
    reg_is("R6 height high", 8'h30, 8'h02);
    cmd(8'h1a); wd(8'hfa);
    reg_is("R6 refresh high", 8'h1a, 8'h0a);
    reg_is("R6 refresh low preserved", 8'h18, 8'h5c);
    cmd(8'h08); wd(8'hc7);
    reg_is("R6 synth low", 8'h08, 8'hc7);
    reg_is("R6 synth high preserved", 8'h0a, 8'h00);

    // R8: gamma table
    cmd(8'hb6); wd(8'h00); cmd(8'hb8);
    for (int i = 0; i < 256; i++) wd(8'((i * 37 + 5) & 255));
    reg_is("R8 pointer wrapped after writes", 8'hb6, 8'h00);
    for (int i = 0; i < 256; i++) reg_is("R8 gamma entry", 8'hb8, 8'((i * 37 + 5) & 255));
    reg_is("R8 pointer wrapped after reads", 8'hb6, 8'h00);

    // R9: filter table
    cmd(8'h58); wd(8'h3e); reg_is("R9 pointer mask", 8'h58, 8'h1e);
    cmd(8'h58); wd(8'h00); cmd(8'h5a);
    for (int i = 0; i < 33; i++) wd(8'(i * 11 + 3));
    reg_is("R9 pointer stops at 32", 8'h58, 8'h20);
    reg_is("R9 read past end", 8'h5a, 8'h00);
    reg_is("R9 pointer held", 8'h58, 8'h20);
    cmd(8'h58); wd(8'h00);
    for (int i = 0; i < 32; i++) reg_is("R9 filter entry", 8'h5a, 8'(i * 11 + 3));

    // R10: interrupt status
    @(negedge clk); irq_set = 8'ha5; @(negedge clk); irq_set = 8'h00;
    chk("R10 irq_out set", {15'h0, irq_out}, 16'h0001);
    reg_is("R10 status set", 8'hf6, 8'ha5);
    cmd(8'hf6); wd(8'h0f); reg_is("R10 write-AND", 8'hf6, 8'h05);
    chk("R10 irq_out still set", {15'h0, irq_out}, 16'h0001);
    cmd(8'hf6); wd(8'h00); reg_is("R10 cleared", 8'hf6, 8'h00);
    chk("R10 irq_out clear", {15'h0, irq_out}, 16'h0000);

    // R11: status bit 5
    cmd(8'he8); wd(8'hff); reg_is("R11 bit5 with mask", 8'he8, 8'h3b);
    cmd(8'he8); wd(8'h00); reg_is("R11 bit5 alone", 8'he8, 8'h20);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule